// File: doc/BRIEF.md
# Prescaled Event Counter Timer

This block counts active edges of an external signal with two cascaded down-counters. The first stage is a prescaler. Each time it underflows, the second stage, the timer, takes one step. When the timer underflows, the block raises a one-cycle interrupt request. Both stages reload from their own reload values when they underflow, so the request repeats every (n+1)(m+1) active edges. Here n is the prescaler value and m is the timer value.

The count input comes from one of two pins. Each pin passes through a two-flop synchronizer. The selected signal then goes to an edge detector that responds to either the rising or the falling edge. Software uses a small write/read register port. One address holds the mode (run, edge polarity, pin select). One address accesses the prescaler and one accesses the timer. A read of either stage returns its live count.

The control state machine has four states:
- `ST_STOP`: stopped.
- `ST_RUN`: counting.
- `ST_ARM`: a value was written while running and waits for the edge that latches it into the reload register.
- `ST_XFER`: the reload value waits for the edge that copies it into the counters.

The transitions are:
- `ST_STOP`→`ST_RUN` on a mode write with run=1.
- `ST_RUN`→`ST_ARM` on a data write.
- `ST_ARM`→`ST_XFER` on an active edge.
- `ST_XFER`→`ST_RUN` on an active edge.
- `ST_ARM`/`ST_XFER`→`ST_ARM` on another data write.
- Any state→`ST_STOP` on a mode write with run=0.

Top module: `evtcnt_timer`

## Requirements
- R1: On each active edge while in `ST_RUN`, the prescaler decrements by one. When the prescaler is 0 on that edge, it reloads, and the timer takes one step, which is a decrement or, from 0, a reload.
- R2: With prescaler value n and timer value m, exactly one interrupt request occurs per (n+1)(m+1) active edges. After e edges from a fresh load, the prescaler reads n − (e mod (n+1)) and the timer reads m − (⌊e/(n+1)⌋ mod (m+1)).
- R3: `tmr_irq` is high for exactly one clock cycle per timer underflow. It is only raised after an edge on which both counts were 0 in `ST_RUN`.
- R4: Mode bit 0 is the run flag. Writing 1 starts counting and writing 0 stops it. While stopped, active edges change neither count and raise no request. The run flag reads back in bit 0.
- R5: Mode bit 1 selects the active edge: 0 selects rising and 1 selects falling.
- R6: Mode bit 2 selects the count pin: 0 selects `pin_a` and 1 selects `pin_b`. Edges on the unselected pin have no effect.
- R7: A write to the prescaler (address 1) or the timer (address 2) while stopped sets both that stage's reload value and its count on the next clock.
- R8: A write to either stage while running is held back. The first active edge latches it into the reload register, with no counting. The second active edge copies both reload values into both counters. Decrementing resumes on the third edge.
- R9: Reads use address 0 for mode, 1 for the live prescaler count and 2 for the live timer count; address 3 reads 0.
- R10: After reset, the mode reads 0x00, both counts read 0 and `tmr_irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_a | input | 1 | External count input 0, asynchronous |
| pin_b | input | 1 | External count input 1, asynchronous |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| tmr_irq | output | 1 | One-cycle timer underflow request |

## Verification
The assertions assume that active edges of the selected input arrive at least two clocks apart, which any synchronized level toggle ensures. They also assume that a change of pin select or polarity is made only while stopped, so that a spurious edge from the change cannot land in a counting state. The stimulus holds every pin level for four clocks. It changes the mode configuration only while stopped, and it parks both pins at the idle level of the chosen polarity before starting. This means every edge the design sees is one the bench intended.

// File: rtl/evt_pkg.sv
package evt_pkg;

    typedef enum logic [1:0] {
        ST_STOP = 2'd0,
        ST_RUN  = 2'd1,
        ST_ARM  = 2'd2,
        ST_XFER = 2'd3
    } evt_state_e;

    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] REG_MODE = 2'd0;
    localparam logic [ADDR_W-1:0] REG_PRE  = 2'd1;
    localparam logic [ADDR_W-1:0] REG_TMR  = 2'd2;

    localparam int MODE_RUN  = 0;
    localparam int MODE_FALL = 1;
    localparam int MODE_PINB = 2;
    localparam int MODE_W    = 3;

endpackage

// File: rtl/evt_edge_sync.sv
module evt_edge_sync #(
    parameter int NPINS  = 2,
    parameter int STAGES = 2,
    localparam int SEL_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pins,
    input  logic [SEL_W-1:0] sel,
    input  logic             fall,
    output logic             cnt_en
);

    logic [NPINS-1:0] synced;
    logic             muxed;
    logic             prev_q;

    for (genvar i = 0; i < NPINS; i++) begin : g_sync
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '0;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], pins[i]};
            end
        end
        assign synced[i] = chain_q[STAGES-1];
    end

    assign muxed = synced[sel];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= muxed;
        end
    end

    assign cnt_en = fall ? (prev_q & ~muxed) : (~prev_q & muxed);

endmodule

// File: rtl/evt_down_stage.sv
module evt_down_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] wdata,
    input  logic         load_now,
    input  logic         stage_wr,
    input  logic         drop,
    input  logic         latch,
    input  logic         copy,
    input  logic         step,
    output logic [W-1:0] cnt,
    output logic         uf
);

    logic [W-1:0] rl_q;
    logic [W-1:0] stg_q;
    logic         pend_q;

    assign uf = step && (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rl_q   <= '0;
            stg_q  <= '0;
            pend_q <= 1'b0;
            cnt    <= '0;
        end else if (load_now) begin
            rl_q   <= wdata;
            cnt    <= wdata;
            pend_q <= 1'b0;
        end else begin
            if (stage_wr) begin
                stg_q  <= wdata;
                pend_q <= 1'b1;
            end else if (latch || drop) begin
                pend_q <= 1'b0;
            end
            if (latch && pend_q) begin
                rl_q <= stg_q;
            end
            if (copy) begin
                cnt <= rl_q;
            end else if (step) begin
                cnt <= uf ? rl_q : cnt - 1'b1;
            end
        end
    end

endmodule

// File: rtl/evt_ctrl_fsm.sv
module evt_ctrl_fsm
    import evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              cnt_en,
    output evt_state_e        state,
    output logic              mode_fall,
    output logic              mode_pinb,
    output logic              load_pre,
    output logic              load_tmr,
    output logic              stage_pre,
    output logic              stage_tmr,
    output logic              drop,
    output logic              latch,
    output logic              copy,
    output logic              step
);

    evt_state_e nxt;
    logic       wr_mode;
    logic       wr_pre;
    logic       wr_tmr;
    logic       wr_data;

    assign wr_mode = bus_wr && (bus_addr == REG_MODE);
    assign wr_pre  = bus_wr && (bus_addr == REG_PRE);
    assign wr_tmr  = bus_wr && (bus_addr == REG_TMR);
    assign wr_data = wr_pre || wr_tmr;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_STOP: if (wr_mode && mode_wdata[MODE_RUN]) nxt = ST_RUN;
            ST_RUN:  if (wr_data) nxt = ST_ARM;
            ST_ARM: begin
                if (wr_data)     nxt = ST_ARM;
                else if (cnt_en) nxt = ST_XFER;
            end
            ST_XFER: begin
                if (wr_data)     nxt = ST_ARM;
                else if (cnt_en) nxt = ST_RUN;
            end
        endcase
        if (wr_mode && !mode_wdata[MODE_RUN]) nxt = ST_STOP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_STOP;
        end else begin
            state <= nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_fall <= 1'b0;
            mode_pinb <= 1'b0;
        end else if (wr_mode) begin
            mode_fall <= mode_wdata[MODE_FALL];
            mode_pinb <= mode_wdata[MODE_PINB];
        end
    end

    always_comb begin
        load_pre  = wr_pre && (state == ST_STOP);
        load_tmr  = wr_tmr && (state == ST_STOP);
        stage_pre = wr_pre && (state != ST_STOP);
        stage_tmr = wr_tmr && (state != ST_STOP);
        drop      = wr_mode && !mode_wdata[MODE_RUN] && (state != ST_STOP);
        latch     = (state == ST_ARM) && cnt_en;
        copy      = (state == ST_XFER) && cnt_en;
        step      = (state == ST_RUN) && cnt_en;
    end

endmodule

// File: rtl/evtcnt_timer.sv
module evtcnt_timer
    import evt_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_a,
    input  logic              pin_b,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tmr_irq
);

    evt_state_e        state;
    logic              mode_fall;
    logic              mode_pinb;
    logic              cnt_en;
    logic              load_pre, load_tmr;
    logic              stage_pre, stage_tmr;
    logic              drop, latch, copy, step;
    logic [DATA_W-1:0] pre_cnt, tmr_cnt;
    logic              pre_uf, tmr_uf;
    logic [DATA_W-1:0] rd_mode;

    evt_edge_sync #(
        .NPINS  (2),
        .STAGES (SYNC_STAGES)
    ) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins   ({pin_b, pin_a}),
        .sel    (mode_pinb),
        .fall   (mode_fall),
        .cnt_en (cnt_en)
    );

    evt_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .mode_wdata (bus_wdata[MODE_W-1:0]),
        .cnt_en     (cnt_en),
        .state      (state),
        .mode_fall  (mode_fall),
        .mode_pinb  (mode_pinb),
        .load_pre   (load_pre),
        .load_tmr   (load_tmr),
        .stage_pre  (stage_pre),
        .stage_tmr  (stage_tmr),
        .drop       (drop),
        .latch      (latch),
        .copy       (copy),
        .step       (step)
    );

    evt_down_stage #(.W(DATA_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .wdata    (bus_wdata),
        .load_now (load_pre),
        .stage_wr (stage_pre),
        .drop     (drop),
        .latch    (latch),
        .copy     (copy),
        .step     (step),
        .cnt      (pre_cnt),
        .uf       (pre_uf)
    );

    evt_down_stage #(.W(DATA_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wdata    (bus_wdata),
        .load_now (load_tmr),
        .stage_wr (stage_tmr),
        .drop     (drop),
        .latch    (latch),
        .copy     (copy),
        .step     (pre_uf),
        .cnt      (tmr_cnt),
        .uf       (tmr_uf)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_irq <= 1'b0;
        end else begin
            tmr_irq <= tmr_uf;
        end
    end

    always_comb begin
        rd_mode            = '0;
        rd_mode[MODE_RUN]  = (state != ST_STOP);
        rd_mode[MODE_FALL] = mode_fall;
        rd_mode[MODE_PINB] = mode_pinb;
    end

    always_comb begin
        case (bus_addr)
            REG_MODE: bus_rdata = rd_mode;
            REG_PRE:  bus_rdata = pre_cnt;
            REG_TMR:  bus_rdata = tmr_cnt;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/evt_checker.sv
module evt_checker
    import evt_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              tmr_irq,
    input evt_state_e        state,
    input logic              cnt_en,
    input logic [DATA_W-1:0] pre_cnt,
    input logic [DATA_W-1:0] tmr_cnt
);

    AST_RUN_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && cnt_en && pre_cnt != '0) |=> (pre_cnt == $past(pre_cnt) - 1'b1)); // R1

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_irq |=> !tmr_irq); // R3

    AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_irq |-> $past(state == ST_RUN && cnt_en && pre_cnt == '0 && tmr_cnt == '0)); // R3

    AST_STOP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && !bus_wr) |=> ($stable(pre_cnt) && $stable(tmr_cnt))); // R4

    AST_LOAD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && bus_wr && bus_addr == REG_TMR) |=> (tmr_cnt == $past(bus_wdata))); // R7

    AST_ARM_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARM && !bus_wr) |=> ($stable(pre_cnt) && $stable(tmr_cnt))); // R8

endmodule

bind evtcnt_timer evt_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .tmr_irq   (tmr_irq),
    .state     (state),
    .cnt_en    (cnt_en),
    .pre_cnt   (pre_cnt),
    .tmr_cnt   (tmr_cnt)
);

// File: tb/evtcnt_timer_tb.sv
module evtcnt_timer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_a = 1'b0;
    logic       pin_b = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       tmr_irq;

    int checks = 0;
    int fails = 0;
    int irq_seen = 0;
    int irq_run = 0;
    int irq_max_run = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    evtcnt_timer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_a     (pin_a),
        .pin_b     (pin_b),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tmr_irq   (tmr_irq)
    );

    // {n, m, edges, irq count, prescaler read, timer read, mode config}
    // mode config: bit1 falling edge, bit2 pin_b
    localparam logic [55:0] VEC [0:5] = '{
        {8'd0, 8'd0, 8'd5,  8'd5, 8'd0, 8'd0, 8'h00},
        {8'd1, 8'd2, 8'd6,  8'd1, 8'd1, 8'd2, 8'h02},
        {8'd2, 8'd1, 8'd7,  8'd1, 8'd1, 8'd1, 8'h04},
        {8'd3, 8'd3, 8'd20, 8'd1, 8'd3, 8'd2, 8'h06},
        {8'd0, 8'd4, 8'd12, 8'd2, 8'd0, 8'd2, 8'h00},
        {8'd4, 8'd0, 8'd9,  8'd1, 8'd0, 8'd0, 8'h02}
    };

    always @(negedge clk) begin
        if (tmr_irq) begin
            irq_seen++;
            irq_run++;
            if (irq_run > irq_max_run) irq_max_run = irq_run;
        end else begin
            irq_run = 0;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #2;
        d = bus_rdata;
    endtask

    task automatic drive_pin(input bit use_b, input logic v);
        if (use_b) pin_b = v;
        else       pin_a = v;
    endtask

    task automatic pulse(input bit use_b, input bit fall);
        @(negedge clk);
        drive_pin(use_b, ~fall);
        repeat (4) @(negedge clk);
        drive_pin(use_b, fall);
        repeat (4) @(negedge clk);
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        int base;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        bus_read(2'd0, rd); chk("R10 mode after reset", rd, 8'h00);
        bus_read(2'd1, rd); chk("R10 prescaler after reset", rd, 8'h00);
        bus_read(2'd2, rd); chk("R10 timer after reset", rd, 8'h00);
        chk("R10 irq after reset", {7'd0, tmr_irq}, 8'h00);
        bus_read(2'd3, rd); chk("R9 unused address", rd, 8'h00);

        // table walk: R1 R2 R5 R6
        for (int i = 0; i < 6; i++) begin
            logic [7:0] n, m, ne, eirq, epre, etmr, cfg;
            {n, m, ne, eirq, epre, etmr, cfg} = VEC[i];
            bus_write(2'd0, cfg);
            pin_a = cfg[2] ? 1'b0 : cfg[1];
            pin_b = cfg[2] ? cfg[1] : 1'b0;
            settle();
            bus_write(2'd1, n);
            bus_write(2'd2, m);
            bus_read(2'd1, rd); chk("R7 prescaler load while stopped", rd, n);
            bus_read(2'd2, rd); chk("R7 timer load while stopped", rd, m);
            base = irq_seen;
            bus_write(2'd0, cfg | 8'h01);
            settle();
            for (int e = 0; e < int'(ne); e++) pulse(cfg[2], cfg[1]);
            settle();
            chk("R2 irq count per vector", 8'(irq_seen - base), eirq);
            bus_read(2'd1, rd); chk("R1 prescaler count per vector", rd, epre);
            bus_read(2'd2, rd); chk("R1 timer count per vector", rd, etmr);
        end

        // R8 write while running
        bus_write(2'd0, 8'h00);
        pin_a = 1'b0; pin_b = 1'b0;
        settle();
        bus_write(2'd1, 8'd1);
        bus_write(2'd2, 8'd5);
        bus_write(2'd0, 8'h01);
        bus_read(2'd0, rd); chk("R4 run flag reads back", rd, 8'h01);
        settle();
        bus_write(2'd1, 8'd3);
        bus_read(2'd1, rd); chk("R9 read shows count not pending value", rd, 8'd1);
        pulse(1'b0, 1'b0);
        bus_read(2'd1, rd); chk("R8 first edge does not count", rd, 8'd1);
        bus_read(2'd2, rd); chk("R8 first edge timer unchanged", rd, 8'd5);
        pulse(1'b0, 1'b0);
        bus_read(2'd1, rd); chk("R8 second edge copies reload", rd, 8'd3);
        bus_read(2'd2, rd); chk("R8 second edge timer copy", rd, 8'd5);
        pulse(1'b0, 1'b0);
        bus_read(2'd1, rd); chk("R8 third edge decrements", rd, 8'd2);
        pulse(1'b0, 1'b0);
        bus_read(2'd1, rd); chk("R8 fourth edge decrements", rd, 8'd1);

        // R6 unselected pin ignored while counting on pin_a
        for (int k = 0; k < 3; k++) pulse(1'b1, 1'b0);
        settle();
        bus_read(2'd1, rd); chk("R6 unselected pin ignored", rd, 8'd1);

        // R5 falling edges ignored in rising mode: hold high, then lower
        @(negedge clk); pin_a = 1'b1;
        settle();
        bus_read(2'd1, rd); chk("R5 rising edge counted", rd, 8'd0);
        @(negedge clk); pin_a = 1'b0;
        settle();
        bus_read(2'd1, rd); chk("R5 falling edge ignored in rising mode", rd, 8'd0);

        // R4 stop holds counts and suppresses requests
        bus_write(2'd0, 8'h00);
        bus_read(2'd0, rd); chk("R4 run flag cleared", rd, 8'h00);
        base = irq_seen;
        for (int k = 0; k < 8; k++) pulse(1'b0, 1'b0);
        settle();
        bus_read(2'd1, rd); chk("R4 prescaler frozen when stopped", rd, 8'd0);
        bus_read(2'd2, rd); chk("R4 timer frozen when stopped", rd, 8'd5);
        chk("R4 no request when stopped", 8'(irq_seen - base), 8'd0);

        // R3 pulse width
        chk("R3 request lasts one cycle", 8'(irq_max_run), 8'd1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule